// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder

This block adds or subtracts two single-precision binary floating-point operands and returns the result one clock after the operands are presented. The datapath has four steps. It unpacks each operand and restores the hidden leading one. It shifts the smaller operand right to match the larger exponent. It adds or subtracts the significands. It then normalises the result and rounds it to the nearest representable value, with ties going to the even value.

Three extra bits sit below the significand through alignment and normalisation: a guard bit, a round bit, and a sticky bit that collects every nonzero bit shifted past them. Because of these bits the rounded result equals the exact sum rounded once. Three flags come with each result: exponent overflow, exponent underflow and inexact. Subnormal inputs are read as zero. A result too small to be normal is flushed to zero. Rounding always goes to the nearest value.

Top module: `fp_add_sp`

## Requirements
- R1: Operands and result use one format: bit 31 is the sign, bits 30:23 are the exponent biased by 127, and bits 22:0 are the fraction below an implicit leading one. When sub_i is 1 the block computes a_i minus b_i by inverting the sign of b_i; when sub_i is 0 it computes a_i plus b_i.
- R2: A result, its flags and valid_o appear on the clock edge after the edge that samples valid_i high. When valid_i was low at the previous edge, valid_o is low and sum_o keeps its last value.
- R3: For finite normal operands with a normal result, sum_o is the exact sum rounded to a 24-bit significand, to the nearest value, with ties going to an even last fraction bit.
- R4: inexact_o is 1 exactly when the delivered result differs from the exact sum. This includes every overflow and every underflow result.
- R5: When rounding carries out of the significand, the exponent rises by one and the fraction becomes zero.
- R6: When the rounded exponent reaches 255, the result is infinity (exponent 255, fraction 0) with the sign of the exact sum, and ovf_o and inexact_o are 1.
- R7: When the normalised exponent before rounding is below 1, the result is a zero with the sign of the exact sum, and unf_o and inexact_o are 1. The block never outputs an exponent of 0 with a nonzero fraction.
- R8: An operand with exponent field 0 is read as a zero of its own sign, whatever its fraction. Adding such an operand to a normal x returns x exactly, with no flag set.
- R9: An exact zero from two nonzero operands of opposite effective sign is +0. The sum of two zeros is -0 only when both effective signs are negative; otherwise it is +0.
- R10: An operand with exponent field 255 is read as infinity. The result is then infinity with the sign of a_i if a_i is infinite, and otherwise with the effective sign of b_i. No flag is set.
- R11: ovf_o, unf_o and inexact_o are 0 whenever valid_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands present this cycle |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| sub_i | input | 1 | 1 selects a_i minus b_i |
| valid_o | output | 1 | Result present |
| sum_o | output | 32 | Rounded result |
| ovf_o | output | 1 | Exponent overflow; result is infinity |
| unf_o | output | 1 | Exponent underflow; result flushed to zero |
| inexact_o | output | 1 | Result differs from the exact sum |

## Verification
Every error in this block is visible on sum_o or the flags in the cycle after the operands are presented. No state carries from one operation to the next, so a fault cannot stay hidden for later cycles. A sticky bit that is lost or wrongly set during alignment shows up as a one-ulp error on near-tie operands and as a wrong inexact_o. A wrong leading-zero count shows up as a wrong exponent after cancellation. The stimulus therefore mixes near-equal exponents, large exponent gaps, exact ties, cancellations and carries out of the rounding step. Every result is compared with an exact wide-integer sum that is rounded separately in the bench.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;
  localparam int EXP_W   = 8;
  localparam int FRAC_W  = 23;
  localparam int SIG_W   = FRAC_W + 1;
  localparam int GRS_W   = 3;
  localparam int EXT_W   = SIG_W + GRS_W;
  localparam int EI_W    = EXP_W + 2;
  localparam int LZ_W    = $clog2(EXT_W + 1);
  localparam int EXP_MAX = (1 << EXP_W) - 1;

  typedef struct packed {
    logic              sign;
    logic [EXP_W-1:0]  exp;
    logic [FRAC_W-1:0] frac;
  } fp_t;
endpackage

// File: rtl/fpadd_lzc.sv
module fpadd_lzc #(
  parameter int W   = 27,
  parameter int C_W = $clog2(W + 1)
) (
  input  logic [W-1:0]   vec_i,
  output logic [C_W-1:0] cnt_o
);
  always_comb begin
    cnt_o = C_W'(W);
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) cnt_o = C_W'(W - 1 - i);
    end
  end
endmodule

// File: rtl/fpadd_align.sv
module fpadd_align
  import fpadd_pkg::*;
(
  input  fp_t              a_i,
  input  fp_t              b_i,
  input  logic             sub_i,
  output logic             inf_o,
  output logic             inf_sign_o,
  output logic             eff_sub_o,
  output logic             sign_l_o,
  output logic             zero_sign_o,
  output logic [EXP_W-1:0] exp_l_o,
  output logic [EXT_W-1:0] sig_l_o,
  output logic [EXT_W-1:0] sig_s_o
);
  localparam int WIDE_W = 2 * EXT_W;

  logic              a_zero, b_zero, sign_b, a_ge;
  logic [SIG_W-1:0]  ma, mb, sig_s_raw;
  logic [EXP_W-1:0]  exp_s, diff;
  logic [EXP_W-1:0]  shamt;
  logic [WIDE_W-1:0] wide;

  assign a_zero = (a_i.exp == '0);
  assign b_zero = (b_i.exp == '0);
  assign sign_b = b_i.sign ^ sub_i;
  assign ma     = a_zero ? '0 : {1'b1, a_i.frac};
  assign mb     = b_zero ? '0 : {1'b1, b_i.frac};
  assign a_ge   = {a_i.exp, ma} >= {b_i.exp, mb};

  assign inf_o      = (a_i.exp == EXP_W'(EXP_MAX)) || (b_i.exp == EXP_W'(EXP_MAX));
  assign inf_sign_o = (a_i.exp == EXP_W'(EXP_MAX)) ? a_i.sign : sign_b;
  assign eff_sub_o  = a_i.sign ^ sign_b;
  assign zero_sign_o = a_i.sign & sign_b;

  assign sign_l_o  = a_ge ? a_i.sign : sign_b;
  assign exp_l_o   = a_ge ? a_i.exp  : b_i.exp;
  assign exp_s     = a_ge ? b_i.exp  : a_i.exp;
  assign sig_l_o   = {(a_ge ? ma : mb), {GRS_W{1'b0}}};
  assign sig_s_raw = a_ge ? mb : ma;

  assign diff  = exp_l_o - exp_s;
  assign shamt = (diff > EXP_W'(EXT_W)) ? EXP_W'(EXT_W) : diff;
  assign wide  = {sig_s_raw, {GRS_W{1'b0}}, {EXT_W{1'b0}}} >> shamt;
  // shifted-out bits fold into the sticky position
  assign sig_s_o = {wide[WIDE_W-1:EXT_W+1], wide[EXT_W] | (|wide[EXT_W-1:0])};
endmodule

// File: rtl/fpadd_addnorm.sv
module fpadd_addnorm
  import fpadd_pkg::*;
(
  input  logic                   eff_sub_i,
  input  logic [EXP_W-1:0]       exp_l_i,
  input  logic [EXT_W-1:0]       sig_l_i,
  input  logic [EXT_W-1:0]       sig_s_i,
  output logic                   zero_o,
  output logic [EXT_W-1:0]       norm_o,
  output logic signed [EI_W-1:0] exp_o
);
  logic [EXT_W:0]  sum;
  logic [LZ_W-1:0] lz;

  assign sum = eff_sub_i ? ({1'b0, sig_l_i} - {1'b0, sig_s_i})
                         : ({1'b0, sig_l_i} + {1'b0, sig_s_i});
  assign zero_o = (sum == '0);

  fpadd_lzc #(.W(EXT_W), .C_W(LZ_W)) u_lzc (
    .vec_i (sum[EXT_W-1:0]),
    .cnt_o (lz)
  );

  always_comb begin
    if (sum[EXT_W]) begin
      norm_o = {sum[EXT_W:2], sum[1] | sum[0]};
      exp_o  = $signed({2'b00, exp_l_i}) + EI_W'(1);
    end else begin
      norm_o = sum[EXT_W-1:0] << lz;
      exp_o  = $signed({2'b00, exp_l_i}) - $signed({{(EI_W-LZ_W){1'b0}}, lz});
    end
  end
endmodule

// File: rtl/fpadd_round.sv
module fpadd_round
  import fpadd_pkg::*;
(
  input  logic                   sign_i,
  input  logic [EXT_W-1:0]       norm_i,
  input  logic signed [EI_W-1:0] exp_i,
  output fp_t                    res_o,
  output logic                   ovf_o,
  output logic                   unf_o,
  output logic                   inx_o
);
  logic                   up, carry;
  logic [SIG_W:0]         rnd;
  logic signed [EI_W-1:0] exp_r;
  logic [FRAC_W-1:0]      frac_r;

  // nearest, ties to even
  assign up     = norm_i[2] & (norm_i[1] | norm_i[0] | norm_i[3]);
  assign rnd    = {1'b0, norm_i[EXT_W-1:GRS_W]} + (SIG_W+1)'(up);
  assign carry  = rnd[SIG_W];
  assign frac_r = carry ? rnd[FRAC_W:1] : rnd[FRAC_W-1:0];
  assign exp_r  = exp_i + EI_W'(carry);

  always_comb begin
    res_o = '{sign: sign_i, exp: exp_r[EXP_W-1:0], frac: frac_r};
    ovf_o = 1'b0;
    unf_o = 1'b0;
    inx_o = |norm_i[GRS_W-1:0];
    if (exp_i < EI_W'(1)) begin
      res_o = '{sign: sign_i, exp: '0, frac: '0};
      unf_o = 1'b1;
      inx_o = 1'b1;
    end else if (exp_r >= EI_W'(EXP_MAX)) begin
      res_o = '{sign: sign_i, exp: EXP_W'(EXP_MAX), frac: '0};
      ovf_o = 1'b1;
      inx_o = 1'b1;
    end
  end
endmodule

// File: rtl/fp_add_sp.sv
module fp_add_sp
  import fpadd_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        valid_i,
  input  logic [31:0] a_i,
  input  logic [31:0] b_i,
  input  logic        sub_i,
  output logic        valid_o,
  output logic [31:0] sum_o,
  output logic        ovf_o,
  output logic        unf_o,
  output logic        inexact_o
);
  logic                   inf, inf_sign, eff_sub, sign_l, zero_sign, sum_zero;
  logic [EXP_W-1:0]       exp_l;
  logic [EXT_W-1:0]       sig_l, sig_s, norm;
  logic signed [EI_W-1:0] norm_exp;
  fp_t                    rnd_res, res_d;
  logic                   rnd_ovf, rnd_unf, rnd_inx, ovf_d, unf_d, inx_d;

  fpadd_align u_align (
    .a_i         (fp_t'(a_i)),
    .b_i         (fp_t'(b_i)),
    .sub_i       (sub_i),
    .inf_o       (inf),
    .inf_sign_o  (inf_sign),
    .eff_sub_o   (eff_sub),
    .sign_l_o    (sign_l),
    .zero_sign_o (zero_sign),
    .exp_l_o     (exp_l),
    .sig_l_o     (sig_l),
    .sig_s_o     (sig_s)
  );

  fpadd_addnorm u_addnorm (
    .eff_sub_i (eff_sub),
    .exp_l_i   (exp_l),
    .sig_l_i   (sig_l),
    .sig_s_i   (sig_s),
    .zero_o    (sum_zero),
    .norm_o    (norm),
    .exp_o     (norm_exp)
  );

  fpadd_round u_round (
    .sign_i (sign_l),
    .norm_i (norm),
    .exp_i  (norm_exp),
    .res_o  (rnd_res),
    .ovf_o  (rnd_ovf),
    .unf_o  (rnd_unf),
    .inx_o  (rnd_inx)
  );

  always_comb begin
    res_d = rnd_res;
    ovf_d = rnd_ovf;
    unf_d = rnd_unf;
    inx_d = rnd_inx;
    if (inf) begin
      res_d = '{sign: inf_sign, exp: EXP_W'(EXP_MAX), frac: '0};
      {ovf_d, unf_d, inx_d} = 3'b000;
    end else if (sum_zero) begin
      // cancellation gives +0; two zeros keep a shared negative sign
      res_d = '{sign: eff_sub ? 1'b0 : zero_sign, exp: '0, frac: '0};
      {ovf_d, unf_d, inx_d} = 3'b000;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      sum_o     <= '0;
      ovf_o     <= 1'b0;
      unf_o     <= 1'b0;
      inexact_o <= 1'b0;
    end else begin
      valid_o   <= valid_i;
      ovf_o     <= valid_i & ovf_d;
      unf_o     <= valid_i & unf_d;
      inexact_o <= valid_i & inx_d;
      if (valid_i) sum_o <= res_d;
    end
  end
endmodule

// File: rtl/fp_add_sp_chk.sv
module fp_add_sp_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic        valid_o,
  input logic [31:0] sum_o,
  input logic        ovf_o,
  input logic        unf_o,
  input logic        inexact_o
);
  AST_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(sum_o))); // R2
  AST_OVF_INF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ovf_o) |-> (sum_o[30:23] == 8'hFF && sum_o[22:0] == 23'd0 && inexact_o)); // R6
  AST_UNF_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && unf_o) |-> (sum_o[30:0] == 31'd0 && inexact_o && !ovf_o)); // R7
  AST_NO_SUBNORMAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (sum_o[30:23] != 8'h00 || sum_o[22:0] == 23'd0)); // R7
  AST_IDLE_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (!ovf_o && !unf_o && !inexact_o)); // R11
endmodule

bind fp_add_sp fp_add_sp_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .valid_o   (valid_o),
  .sum_o     (sum_o),
  .ovf_o     (ovf_o),
  .unf_o     (unf_o),
  .inexact_o (inexact_o)
);

// File: tb/sim_fp_add_sp.sv
module sim_fp_add_sp;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 200000;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        valid_i = 1'b0, sub_i = 1'b0;
  logic [31:0] a_i = '0, b_i = '0;
  logic        valid_o, ovf_o, unf_o, inexact_o;
  logic [31:0] sum_o;

  int total = 0, bad = 0;
  bit done = 1'b0;
  logic [35:0] exp_q[$];   // {valid, sum, ovf, unf, inx}
  string       tag_q[$];
  logic [31:0] last_sum = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_add_sp u0 (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .a_i(a_i), .b_i(b_i),
    .sub_i(sub_i), .valid_o(valid_o), .sum_o(sum_o), .ovf_o(ovf_o),
    .unf_o(unf_o), .inexact_o(inexact_o)
  );

  // exact wide-integer sum, rounded once; result {sum, ovf, unf, inx}
  function automatic logic [34:0] ref_add(input logic [31:0] a, input logic [31:0] b, input logic sub);
    logic sa, sb, sr, inx;
    int ea, eb, emin, p, k, e;
    logic [299:0] ma, mb, v, mant, rem, half;
    sa = a[31]; sb = b[31] ^ sub;
    ea = int'(a[30:23]); eb = int'(b[30:23]);
    if (ea == 255) return {sa, 8'hFF, 23'd0, 3'b000};
    if (eb == 255) return {sb, 8'hFF, 23'd0, 3'b000};
    ma = (ea == 0) ? '0 : 300'({1'b1, a[22:0]});
    mb = (eb == 0) ? '0 : 300'({1'b1, b[22:0]});
    if (ma == '0 && mb == '0) return {sa & sb, 31'd0, 3'b000};
    emin = (ea < eb) ? ea : eb;
    ma = ma << (ea - emin);
    mb = mb << (eb - emin);
    if (sa == sb) begin v = ma + mb; sr = sa; end
    else if (ma >= mb) begin v = ma - mb; sr = sa; end
    else begin v = mb - ma; sr = sb; end
    if (v == '0) return 35'd0;
    p = 0;
    for (int i = 0; i < 300; i++) if (v[i]) p = i;
    e = emin + p - 23;
    if (e < 1) return {sr, 31'd0, 3'b011};
    inx = 1'b0;
    if (p > 23) begin
      k = p - 23;
      mant = v >> k;
      rem  = v & ((300'd1 << k) - 300'd1);
      half = 300'd1 << (k - 1);
      inx  = (rem != '0);
      if (rem > half || (rem == half && mant[0])) mant = mant + 300'd1;
    end else begin
      mant = v << (23 - p);
    end
    if (mant[24]) begin mant = mant >> 1; e = e + 1; end
    if (e >= 255) return {sr, 8'hFF, 23'd0, 3'b101};
    return {sr, e[7:0], mant[22:0], 3'b000 | {2'b00, inx}};
  endfunction

  task automatic step(input logic v, input logic [31:0] a, input logic [31:0] b,
                      input logic s, input string tag);
    @(negedge clk);
    valid_i = v; a_i = a; b_i = b; sub_i = s;
    exp_q.push_back({v, v ? ref_add(a, b, s) : 35'd0});
    tag_q.push_back(tag);
  endtask

  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (exp_q.size() > 0) begin
      logic [35:0] ex;
      string t;
      ex = exp_q.pop_front();
      t  = tag_q.pop_front();
      total++;
      if (ex[35]) begin
        if (valid_o !== 1'b1 || sum_o !== ex[34:3] || {ovf_o, unf_o, inexact_o} !== ex[2:0]) begin
          bad++;
          $display("FAIL %s: got v=%b sum=%h f=%b%b%b exp v=1 sum=%h f=%b",
                   t, valid_o, sum_o, ovf_o, unf_o, inexact_o, ex[34:3], ex[2:0]);
        end
        last_sum = ex[34:3];
      end else if (valid_o !== 1'b0 || sum_o !== last_sum || {ovf_o, unf_o, inexact_o} !== 3'b000) begin
        bad++;
        $display("FAIL R2 R11 idle: got v=%b sum=%h f=%b%b%b exp v=0 sum=%h f=000",
                 valid_o, sum_o, ovf_o, unf_o, inexact_o, last_sum);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * WD_CYCLES);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got hang exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (valid_o !== 1'b0 || sum_o !== 32'd0 || {ovf_o, unf_o, inexact_o} !== 3'b000) begin
      bad++;
      $display("FAIL R2 reset: got v=%b sum=%h exp v=0 sum=0", valid_o, sum_o);
    end
    rst_ni = 1'b1;
    step(1, 32'h3F800000, 32'h3F800000, 0, "R1 R3 1+1");
    step(1, 32'h40400000, 32'h3F800000, 1, "R1 3-1 sub");
    step(0, 32'h12345678, 32'h12345678, 0, "R2 idle");
    step(1, 32'h3F800000, 32'h33800000, 0, "R3 R4 tie to even down");
    step(1, 32'h3F800001, 32'h33800000, 0, "R3 R4 tie to even up");
    step(1, 32'h3F800000, 32'h33C00000, 0, "R3 R4 above half");
    step(1, 32'h3F7FFFFF, 32'h33000000, 0, "R5 round carry");
    step(1, 32'h7F7FFFFF, 32'h7F7FFFFF, 0, "R6 overflow");
    step(1, 32'hFF7FFFFF, 32'h7F7FFFFF, 1, "R6 negative overflow");
    step(1, 32'h00800000, 32'h00800001, 1, "R7 underflow");
    step(1, 32'h00000001, 32'h3F800000, 0, "R8 subnormal a");
    step(1, 32'hC0490FDB, 32'h807FFFFF, 0, "R8 subnormal b");
    step(1, 32'h3F800000, 32'h3F800000, 1, "R9 cancel");
    step(1, 32'h80000000, 32'h00000000, 1, "R9 neg zeros");
    step(1, 32'h80000000, 32'h00000000, 0, "R9 mixed zeros");
    step(1, 32'h7F800000, 32'hFF800000, 0, "R10 inf a");
    step(1, 32'h3F800000, 32'h7F800000, 1, "R10 inf b sub");
    step(1, 32'h4B000000, 32'h3F000000, 1, "R3 R4 sub sticky");
    step(1, 32'h3F800000, 32'h0C000001, 1, "R3 R4 far gap");
    step(0, 32'h0, 32'h0, 0, "R2 idle");
    step(0, 32'h0, 32'h0, 0, "R2 idle");
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] a, b;
      int ea, eb;
      ea = 1 + int'($urandom % 254);
      eb = ea + int'($urandom % 61) - 30;
      if (n % 7 == 0) eb = 1 + int'($urandom % 254);
      if (eb < 0) eb = 0;
      if (eb > 254) eb = 254;
      if (n % 97 == 0) eb = 0;
      if (n % 131 == 0) ea = 255;
      a = {1'($urandom), ea[7:0], 23'($urandom)};
      b = {1'($urandom), eb[7:0], 23'($urandom)};
      if (n % 5 == 0) b[22:0] = a[22:0] ^ 23'(($urandom % 4));
      if (n % 11 == 0) b[2:0] = 3'b000;
      step(n % 13 != 0, a, b, 1'($urandom), "R3 R4 R5 R6 R7 random");
    end
    step(0, 32'h0, 32'h0, 0, "R2 idle");
    while (exp_q.size() > 0) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule